// File: doc/BRIEF.md
# SCL Clock Generator with Stretch and Synchronization

This block produces the serial clock of a two-wire bus master for standard, fast and fast-plus rates. It times the low and high halves of each clock period in peripheral-clock cycles. Two separate 8-bit settings give the lengths. The block pulls the wire low through an open-drain enable and otherwise leaves it released.

The block reads back the wired clock line through a two-flop synchronizer. Each phase starts from what the line actually shows, not from what the block drives. A high phase begins only once the line has been seen low and then high again. A slave that holds the line low therefore stretches the period. Another master that pulls the line low ends the high phase early, and the block then runs a full low phase of its own.

The data path receives two single-cycle strobes: one at the first cycle of each low phase, which is the data change point, and one at the first cycle of each high phase, which is the sample point. The block stops driving at once when arbitration is lost or when it is disabled. A stop request lets the current high phase finish and then leaves the line released.

Top module: `scl_clkgen`

## Requirements
- R1: During and right after reset, scl_drive_low_o, low_start_o and high_start_o are all 0.
- R2: A low phase drives scl_drive_low_o = 1 for exactly lo_cnt_i + 1 cycles. low_start_o is 1 only in the first of those cycles.
- R3: The clock line input passes through a two-flop synchronizer. After release, a high phase starts only when the synchronized line has been seen low and then high. On an uncontested bus, high_start_o rises in the third cycle after release.
- R4: An uncontested high phase lasts hi_cnt_i + 1 cycles with scl_drive_low_o = 0. It is followed at once by the next low phase.
- R5: If the line goes low during a high phase, scl_drive_low_o and low_start_o assert in the third cycle after the line falls, and that low phase still lasts lo_cnt_i + 1 cycles.
- R6: When arb_lost_i is 1, scl_drive_low_o is 0 from the next cycle on, and no strobe fires while arb_lost_i stays 1.
- R7: When en_i is 0, scl_drive_low_o is 0 from the next cycle on, no strobe fires, and the phase counter stays at zero.
- R8: While stop_req_i is 1, an idle block does not start. A stop request seen at the end of a high phase ends generation with the line released and no further low_start_o.
- R9: Counts of 0 give one-cycle low and high phases.
- R10: While an external device holds the line low after release, the block keeps it released and holds back high_start_o. The high phase starts in the third cycle after the line comes up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock, the only time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables clock generation |
| stop_req_i | input | 1 | Finish after the current high phase; blocks a start from idle |
| arb_lost_i | input | 1 | Arbitration lost: stop driving immediately |
| hi_cnt_i | input | 8 | High phase length minus one, in clock cycles |
| lo_cnt_i | input | 8 | Low phase length minus one, in clock cycles |
| scl_in_i | input | 1 | Sampled level of the wired clock line |
| scl_drive_low_o | output | 1 | Open-drain enable: 1 pulls the clock line low |
| low_start_o | output | 1 | One-cycle strobe in the first low-phase cycle |
| high_start_o | output | 1 | One-cycle strobe in the first high-phase cycle |

## Verification
A phase state or counter that is off shows at the ports as a low or high width that is wrong by whole cycles. The bench measures every width in the first period after enable, so such an error appears within one clock period. A missing synchronizer stage or a missing seen-low flag moves high_start_o earlier than the fixed three-cycle release latency. With zero counts, a stale synchronizer value would start the high phase too early, and the bench catches this in the first period. A release path that ignores arbitration or disable leaves scl_drive_low_o set one cycle after the request, and the bench checks exactly that cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH   = 2'd3
    } scl_state_e;

    typedef struct packed {
        scl_state_e state;
        logic       seen_low;
        logic       low_stb;
        logic       high_stb;
    } scl_regs_t;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stage_d[g] = async_i;
            end else begin : g_rest
                always_comb stage_d[g] = stage_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= {STAGES{RESET_VAL}};
        else         stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)               cnt_d = '0;
        else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             stop_req_i,
    input  logic             arb_lost_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             scl_in_i,
    output logic             scl_drive_low_o,
    output logic             low_start_o,
    output logic             high_start_o
);
    scl_regs_t        r_d;
    scl_regs_t        r_q;
    logic             scl_sync;
    logic             cnt_clr;
    logic             cnt_done;
    logic [CNT_W-1:0] cnt_limit;
    logic [CNT_W-1:0] cnt_val;

    scl_line_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (scl_in_i),
        .sync_o  (scl_sync)
    );

    assign cnt_limit = (r_q.state == ST_HIGH) ? hi_cnt_i : lo_cnt_i;

    scl_phase_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (cnt_clr),
        .limit_i (cnt_limit),
        .cnt_o   (cnt_val),
        .done_o  (cnt_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.low_stb  = 1'b0;
        r_d.high_stb = 1'b0;

        if (!en_i || arb_lost_i) begin
            r_d.state    = ST_IDLE;
            r_d.seen_low = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (!stop_req_i) begin
                        r_d.state    = ST_LOW;
                        r_d.low_stb  = 1'b1;
                        r_d.seen_low = 1'b0;
                    end
                end
                ST_LOW: begin
                    if (!scl_sync) r_d.seen_low = 1'b1;
                    if (cnt_done)  r_d.state    = ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (!scl_sync) begin
                        r_d.seen_low = 1'b1;
                    end else if (r_q.seen_low) begin
                        r_d.state    = ST_HIGH;
                        r_d.high_stb = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (!scl_sync) begin
                        r_d.state    = ST_LOW;
                        r_d.low_stb  = 1'b1;
                        r_d.seen_low = 1'b0;
                    end else if (cnt_done) begin
                        if (stop_req_i) begin
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.state    = ST_LOW;
                            r_d.low_stb  = 1'b1;
                            r_d.seen_low = 1'b0;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end

        cnt_clr = (r_d.state != r_q.state) ||
                  (r_q.state == ST_IDLE)   ||
                  (r_q.state == ST_WAIT_HI);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state    <= ST_IDLE;
            r_q.seen_low <= 1'b0;
            r_q.low_stb  <= 1'b0;
            r_q.high_stb <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low_o = (r_q.state == ST_LOW);
    assign low_start_o     = r_q.low_stb;
    assign high_start_o    = r_q.high_stb;

    AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arb_lost_i |=> (!scl_drive_low_o && !low_start_o && !high_start_o)); // R6

    AST_DISABLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!scl_drive_low_o && !low_start_o && !high_start_o)); // R7

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_IDLE) |-> (cnt_val == '0)); // R7

    AST_HIGH_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        high_start_o |-> $past(scl_sync)); // R3

    AST_LOW_STROBE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_start_o |-> scl_drive_low_o); // R2

    AST_LOW_WITHIN_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.state == ST_LOW) && $stable(lo_cnt_i)) |-> (cnt_val <= lo_cnt_i)); // R2

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({low_start_o, high_start_o}) <= 1); // R4
endmodule

// File: tb/scl_clkgen_test.sv
module scl_clkgen_test;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en_i = 1'b0;
    logic       stop_req_i = 1'b0;
    logic       arb_lost_i = 1'b0;
    logic [7:0] hi_cnt_i = 8'd0;
    logic [7:0] lo_cnt_i = 8'd0;
    logic       ext_hold = 1'b0;
    logic       scl_in_i;
    logic       scl_drive_low_o;
    logic       low_start_o;
    logic       high_start_o;

    int checks = 0;
    int errors = 0;

    always #10 clk_i = ~clk_i;

    assign scl_in_i = !(scl_drive_low_o || ext_hold);

    scl_clkgen uut (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .en_i            (en_i),
        .stop_req_i      (stop_req_i),
        .arb_lost_i      (arb_lost_i),
        .hi_cnt_i        (hi_cnt_i),
        .lo_cnt_i        (lo_cnt_i),
        .scl_in_i        (scl_in_i),
        .scl_drive_low_o (scl_drive_low_o),
        .low_start_o     (low_start_o),
        .high_start_o    (high_start_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        en_i = 1'b0; ext_hold = 1'b0; arb_lost_i = 1'b0; stop_req_i = 1'b0;
        repeat (4) @(negedge clk_i);
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk_i);
        check(!scl_drive_low_o, "R1 drive in reset", scl_drive_low_o, 0);
        check(!low_start_o && !high_start_o, "R1 strobes in reset",
              {low_start_o, high_start_o}, 0);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        check(!scl_drive_low_o, "R1 drive after reset", scl_drive_low_o, 0);
    endtask

    task automatic t_period(input int hi, input int lo, input string req);
        int n;
        int w;
        int h;
        go_idle();
        hi_cnt_i = 8'(hi); lo_cnt_i = 8'(lo); en_i = 1'b1;
        do @(negedge clk_i); while (!low_start_o);
        for (int p = 0; p < 2; p++) begin
            n = 0;
            while (scl_drive_low_o) begin
                if (n > 0) check(!low_start_o, {req, " R2 strobe width"}, 1, 0);
                n++;
                @(negedge clk_i);
            end
            check(n == lo + 1, {req, " R2 low length"}, n, lo + 1);
            w = 0;
            while (!high_start_o) begin
                w++;
                @(negedge clk_i);
            end
            check(w == 3, {req, " R3 release to high"}, w, 3);
            h = 0;
            while (!low_start_o) begin
                if (scl_drive_low_o) check(0, {req, " R4 drive in high"}, 1, 0);
                h++;
                @(negedge clk_i);
            end
            check(h == hi + 1, {req, " R4 high length"}, h, hi + 1);
        end
        go_idle();
    endtask

    task automatic t_stretch();
        int w;
        bit bad;
        go_idle();
        hi_cnt_i = 8'd4; lo_cnt_i = 8'd3; en_i = 1'b1;
        do @(negedge clk_i); while (!low_start_o);
        ext_hold = 1'b1;
        while (scl_drive_low_o) @(negedge clk_i);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (scl_drive_low_o || high_start_o) bad = 1;
            @(negedge clk_i);
        end
        check(!bad, "R10 released and no high while held", bad, 0);
        ext_hold = 1'b0;
        w = 0;
        do begin @(negedge clk_i); w++; end while (!high_start_o && w < 20);
        check(w == 3, "R10 high after line rises", w, 3);
        go_idle();
    endtask

    task automatic t_sync();
        int w;
        int n;
        go_idle();
        hi_cnt_i = 8'd20; lo_cnt_i = 8'd5; en_i = 1'b1;
        do @(negedge clk_i); while (!high_start_o);
        repeat (4) @(negedge clk_i);
        ext_hold = 1'b1;
        w = 0;
        do begin @(negedge clk_i); w++; end while (!scl_drive_low_o && w < 20);
        check(w == 3, "R5 early low latency", w, 3);
        check(low_start_o, "R5 strobe at early low", low_start_o, 1);
        ext_hold = 1'b0;
        n = 0;
        while (scl_drive_low_o) begin n++; @(negedge clk_i); end
        check(n == 6, "R5 full low after sync", n, 6);
        go_idle();
    endtask

    task automatic t_arb();
        bit bad;
        go_idle();
        hi_cnt_i = 8'd6; lo_cnt_i = 8'd6; en_i = 1'b1;
        do @(negedge clk_i); while (!low_start_o);
        arb_lost_i = 1'b1;
        @(negedge clk_i);
        check(!scl_drive_low_o, "R6 release next cycle", scl_drive_low_o, 0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_i);
            if (scl_drive_low_o || low_start_o || high_start_o) bad = 1;
        end
        check(!bad, "R6 quiet while lost", bad, 0);
        go_idle();
    endtask

    task automatic t_disable();
        bit bad;
        go_idle();
        hi_cnt_i = 8'd9; lo_cnt_i = 8'd9; en_i = 1'b1;
        do @(negedge clk_i); while (!low_start_o);
        repeat (2) @(negedge clk_i);
        en_i = 1'b0;
        @(negedge clk_i);
        check(!scl_drive_low_o, "R7 release on disable", scl_drive_low_o, 0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_i);
            if (scl_drive_low_o || low_start_o || high_start_o) bad = 1;
        end
        check(!bad, "R7 quiet while disabled", bad, 0);
        go_idle();
    endtask

    task automatic t_stop();
        bit bad;
        go_idle();
        hi_cnt_i = 8'd5; lo_cnt_i = 8'd4;
        stop_req_i = 1'b1; en_i = 1'b1;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_i);
            if (scl_drive_low_o || low_start_o) bad = 1;
        end
        check(!bad, "R8 no start while stop held", bad, 0);
        stop_req_i = 1'b0;
        do @(negedge clk_i); while (!high_start_o);
        stop_req_i = 1'b1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_i);
            if (scl_drive_low_o || low_start_o) bad = 1;
        end
        check(!bad, "R8 line stays released after stop", bad, 0);
        go_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_period(3, 2, "base");
        t_period(0, 0, "R9 zero");
        t_period(1, 7, "skew");
        t_stretch();
        t_sync();
        t_arb();
        t_disable();
        t_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule